// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block hands the system clock over from a slow secondary oscillator to the main oscillator. A switch request starts a wait sequence, and the sequence depends on the class of the main oscillator. Crystal sources need a start-up wait. A crystal feeding a PLL needs the start-up wait and then a lock wait. RC and external-clock sources need neither. Every class ends with a short settle count of main-oscillator cycles. When the last wait stage finishes, a registered select output moves the clock onto the main source and a one-cycle done pulse is raised.

All oscillator activity reaches the block as single-cycle digital strobes. A main tick marks one cycle of the main oscillator, and a slow tick is a fixed timebase used to measure the lock wait. The analog oscillators, the glitch-free clock multiplexer and the PLL sit outside the block. After the handover the select stays on the main source until a synchronous reset.

Top module: `clksw_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `sel_main`, `busy` and `done` are all 0.
- R2: A `switch_req` seen in idle with the secondary source selected sets `busy` in the next cycle, and `osc_mode` is sampled in that same cycle.
- R3: Mode code 2'b00 (crystal) counts `OST_CYCLES` main ticks, then `SETTLE_CYCLES` main ticks, before it switches.
- R4: Mode code 2'b01 (crystal with PLL) counts `OST_CYCLES` main ticks, then `LOCK_TICKS` slow ticks, then `SETTLE_CYCLES` main ticks.
- R5: Mode code 2'b10 (RC or external clock) counts only `SETTLE_CYCLES` main ticks.
- R6: Mode code 2'b11 behaves exactly like 2'b00.
- R7: Changes on `osc_mode` after the request has been accepted do not change the running sequence.
- R8: A `switch_req` that arrives while `busy` is high is ignored. It neither restarts nor shortens the sequence.
- R9: In the cycle after the tick that completes the final stage, `sel_main` rises, `busy` falls and `done` is high for exactly one cycle.
- R10: Once `sel_main` is 1 it stays 1 until reset, and further requests have no effect.
- R11: Slow ticks do not advance the main-tick stages, and main ticks do not advance the lock stage.
- R12: A reset in the middle of a sequence returns the block to idle with the secondary source selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| switch_req | input | 1 | Request to move onto the main oscillator |
| main_tick | input | 1 | Strobe, one per main-oscillator cycle |
| slow_tick | input | 1 | Strobe from the slow timebase |
| osc_mode | input | 2 | Main-oscillator class: 00 crystal, 01 crystal+PLL, 10 RC/EC, 11 as 00 |
| sel_main | output | 1 | 1 selects the main oscillator |
| busy | output | 1 | Wait sequence in progress |
| done | output | 1 | One-cycle pulse when the select changes |

## Verification
The in-RTL assertions check these properties on every cycle:
- `done` lasts a single cycle.
- `sel_main` rises only together with `done` and never falls outside reset.
- `busy` and `sel_main` are never high together.
- An accepted request raises `busy`.
- A stage counter never passes its limit and holds when no tick arrives.

Three behaviours can only be shown by the bench's scenarios, which compare outputs against a reference model on every clock:
- the exact stage lengths for each mode code, including the reserved code;
- that the mode is sampled only at acceptance;
- that requests arriving while busy, and ticks of the wrong kind, change nothing.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [1:0] {
    MODE_XTAL     = 2'b00,
    MODE_XTAL_PLL = 2'b01,
    MODE_RCEC     = 2'b10,
    MODE_RSVD     = 2'b11
  } osc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STARTUP,
    ST_LOCK,
    ST_SETTLE,
    ST_MAIN
  } seq_state_e;

endpackage

// File: rtl/clksw_mode_decode.sv
module clksw_mode_decode
  import clksw_pkg::*;
(
  input  logic [1:0] mode,
  output logic       need_startup,
  output logic       need_lock
);

  always_comb begin
    need_startup = 1'b1;
    need_lock    = 1'b0;
    case (osc_mode_e'(mode))
      MODE_XTAL:     begin need_startup = 1'b1; need_lock = 1'b0; end
      MODE_XTAL_PLL: begin need_startup = 1'b1; need_lock = 1'b1; end
      MODE_RCEC:     begin need_startup = 1'b0; need_lock = 1'b0; end
      default:       begin need_startup = 1'b1; need_lock = 1'b0; end
    endcase
  end

endmodule

// File: rtl/clksw_stage_counter.sv
module clksw_stage_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  output logic last
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign last = active && tick && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> (cnt_q == $past(cnt_q) || !active || cnt_q == '0));

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int OST_CYCLES    = 1024,
  parameter int LOCK_TICKS    = 20,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       switch_req,
  input  logic       main_tick,
  input  logic       slow_tick,
  input  logic [1:0] osc_mode,
  output logic       sel_main,
  output logic       busy,
  output logic       done
);

  seq_state_e state_q;
  logic       need_lock_q;
  logic       dec_startup, dec_lock;
  logic       st_last, lk_last, se_last;

  clksw_mode_decode u_decode (
    .mode         (osc_mode),
    .need_startup (dec_startup),
    .need_lock    (dec_lock)
  );

  clksw_stage_counter #(.LIMIT(OST_CYCLES)) u_startup_cnt (
    .clk (clk), .rst (rst), .active (state_q == ST_STARTUP),
    .tick (main_tick), .last (st_last)
  );

  clksw_stage_counter #(.LIMIT(LOCK_TICKS)) u_lock_cnt (
    .clk (clk), .rst (rst), .active (state_q == ST_LOCK),
    .tick (slow_tick), .last (lk_last)
  );

  clksw_stage_counter #(.LIMIT(SETTLE_CYCLES)) u_settle_cnt (
    .clk (clk), .rst (rst), .active (state_q == ST_SETTLE),
    .tick (main_tick), .last (se_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      need_lock_q <= 1'b0;
      sel_main    <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (switch_req) begin
            need_lock_q <= dec_lock;
            busy        <= 1'b1;
            state_q     <= dec_startup ? ST_STARTUP : ST_SETTLE;
          end
        end
        ST_STARTUP: begin
          if (st_last) state_q <= need_lock_q ? ST_LOCK : ST_SETTLE;
        end
        ST_LOCK: begin
          if (lk_last) state_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (se_last) begin
            state_q  <= ST_MAIN;
            sel_main <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: state_q <= ST_MAIN;
      endcase
    end
  end

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && switch_req) |=> busy);

  a_r8_busy_excludes_sel: assert property (@(posedge clk) disable iff (rst)
    !(busy && sel_main));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_sel_rise_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_main) |-> done);

  a_r10_sel_sticky: assert property (@(posedge clk) disable iff (rst)
    sel_main |=> sel_main);

endmodule

// File: tb/clksw_seq_tb.sv
module clksw_seq_tb_top;

  localparam int OST  = 16;
  localparam int LOCK = 5;
  localparam int SET  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic mt = 1'b0;
  logic st = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sel, busy, done;

  always #10 clk = ~clk;

  clksw_seq #(.OST_CYCLES(OST), .LOCK_TICKS(LOCK), .SETTLE_CYCLES(SET)) dut_i (
    .clk (clk), .rst (rst), .switch_req (req), .main_tick (mt),
    .slow_tick (st), .osc_mode (mode), .sel_main (sel), .busy (busy), .done (done)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit started = 0;
  bit finished = 0;
  int pm = 50;
  int ps = 33;

  // behavioural reference: 0 idle, 1 startup, 2 lock, 3 settle, 4 on main
  int phase = 0;
  int cnt = 0;
  int mode_l = 0;
  bit e_sel = 0, e_busy = 0, e_done = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      phase = 0; cnt = 0; e_sel = 0; e_busy = 0; e_done = 0;
    end else begin
      e_done = 0;
      if (phase == 0) begin
        if (req) begin
          mode_l = int'(mode);
          phase = (mode_l == 2) ? 3 : 1;
          cnt = 0;
          e_busy = 1;
        end
      end else if (phase == 1) begin
        if (mt) begin
          cnt++;
          if (cnt == OST) begin cnt = 0; phase = (mode_l == 1) ? 2 : 3; end
        end
      end else if (phase == 2) begin
        if (st) begin
          cnt++;
          if (cnt == LOCK) begin cnt = 0; phase = 3; end
        end
      end else if (phase == 3) begin
        if (mt) begin
          cnt++;
          if (cnt == SET) begin
            cnt = 0; phase = 4; e_sel = 1; e_busy = 0; e_done = 1;
          end
        end
      end
    end
  end

  task automatic chk(input string t, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(tag, "sel_main", sel, e_sel);
      chk(tag, "busy", busy, e_busy);
      chk(tag, "done", done, e_done);
    end
  end

  task automatic cyc(input logic r);
    @(negedge clk);
    req = r;
    mt = (($urandom % 100) < pm);
    st = (($urandom % 100) < ps);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req = 0;
    cyc(0); cyc(0);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic run(input logic [1:0] m, input string t, input bit noisy, input bit flip);
    int pulses = 0;
    int guard = 0;
    do_reset();
    tag = t;
    mode = m;
    cyc(1);
    cyc(0);
    chk("R2", "busy after request", busy, 1'b1);
    while (phase != 4 && guard < 3000) begin
      cyc(noisy ? logic'($urandom % 2) : 1'b0);
      if (flip) mode = 2'($urandom);
      if (done) pulses++;
      guard++;
    end
    @(negedge clk);
    if (done) pulses++;
    checks++;
    if (pulses != 1) begin
      fails++;
      $display("FAIL R9 done pulse count actual=%0d expected=1", pulses);
    end
    tag = "R10";
    for (int i = 0; i < 6; i++) cyc(1'b1);
    cyc(0);
    chk("R10", "sel held", sel, 1'b1);
  endtask

  initial begin
    tag = "R1";
    do_reset();
    chk("R1", "sel after reset", sel, 1'b0);
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "done after reset", done, 1'b0);
    run(2'b10, "R5", 0, 0);
    run(2'b00, "R3", 0, 0);
    run(2'b01, "R4", 0, 0);
    run(2'b11, "R6", 0, 0);
    run(2'b01, "R7", 0, 1);
    run(2'b00, "R8", 1, 0);
    pm = 20; ps = 90;
    run(2'b00, "R11", 0, 0);
    pm = 90; ps = 10;
    run(2'b01, "R11", 0, 0);
    pm = 50; ps = 33;
    do_reset();
    tag = "R12";
    mode = 2'b01;
    cyc(1);
    for (int i = 0; i < 20; i++) cyc(0);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    cyc(0);
    chk("R12", "sel after mid reset", sel, 1'b0);
    chk("R12", "busy after mid reset", busy, 1'b0);
    for (int i = 0; i < 10; i++) cyc(0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule